// File: doc/BRIEF.md
# FSK Character Reframer with Host-Clocked Readout

This block sits behind an FSK demodulator. It takes the raw demodulated bit and a carrier-valid qualifier, and recovers asynchronous characters from them. Each character is a start bit, eight data bits and one stop bit. The bit timing comes from a free-running system clock. A fractional phase accumulator produces an oversampling tick at a multiple of the nominal baud rate. A falling edge on the line is taken as a possible start bit. The block confirms it at mid-bit, then samples every later bit at its centre.

The start bit is not kept. At the centre of the stop bit, the eight data bits and the stop bit are loaded together into a nine-bit output register. At the same moment an active-low ready flag is driven low. The host then shifts the bits out on its own read clock, one bit for each rising edge. The ready flag goes high again on the first read edge, or after half a nominal bit time if no edge comes.

The host decides for itself whether to read the ninth (stop) bit to check framing. A status output reports when a new character replaced one that had not been fully read.

Top module: `fsk_char_reframer`

## Requirements
- R1: While reset is held and after it is released, `rdy_n_o` is 1, `data_o` is 1 and `overrun_o` is 0.
- R2: A start bit is accepted only if the line is still low half a bit after the falling edge. For an accepted character, the data bits and the stop bit are loaded at the centre of the stop bit, and `rdy_n_o` falls in that same clock.
- R3: Each rising edge of `dclk_i` puts the next stored bit on `data_o`. The order is data bit 0 (the first bit received) through data bit 7, and the stop bit is ninth. Edges after the ninth give 1. `data_o` changes only on such an edge.
- R4: A `dclk_i` rising edge while `rdy_n_o` is low returns `rdy_n_o` to 1.
- R5: If no `dclk_i` edge arrives, `rdy_n_o` returns to 1 after OVS/2 oversampling ticks, which is half a nominal bit time.
- R6: The stop bit is stored exactly as sampled, and a character whose stop bit is 0 is still loaded and flagged.
- R7: A low pulse on the line that is shorter than half a bit is rejected. No character is loaded and `rdy_n_o` stays 1.
- R8: While `carrier_ok_i` is 0, the line is ignored, the output register is not reloaded, and `rdy_n_o` is held at 1.
- R9: Characters sent at 1212 baud, with the block set for 1200 baud nominal, are received with the correct data.
- R10: At each load, `overrun_o` becomes 1 if fewer than eight bits of the previous character had been read, and 0 otherwise. It changes only at a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_ok_i | input | 1 | Carrier qualifier, 1 = FSK carrier present |
| rx_bit_i | input | 1 | Raw demodulated line bit (idle 1) |
| dclk_i | input | 1 | Host read clock, asynchronous |
| data_o | output | 1 | Serial readout bit |
| rdy_n_o | output | 1 | Character ready, active low |
| overrun_o | output | 1 | Previous character replaced before it was read |

## Verification
The bench sends a short glitch on the line. A design that skipped the mid-bit start confirmation would frame garbage and pull the ready flag low. It also sends characters whose stop bit is 0. A receiver that enforced framing itself would drop them, and one that misordered the readout would put the stop bit anywhere but ninth. The bench times how long the ready flag stays low both with and without a read edge, so a design that ignored one of the two release paths would leave the flag low too long. It also interrupts a readout with a new character and sends a character with the carrier off. This catches a wrong overrun decision and any reload that happens while the qualifier is inactive.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS
  } rx_state_e;
endpackage

// File: rtl/fsk_os_tick.sv
module fsk_os_tick #(
  parameter int CLK_HZ = 3579545,
  parameter int BAUD   = 1200,
  parameter int OVS    = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int AW = $clog2(CLK_HZ) + 1;
  localparam logic [AW:0] STEP_V = (AW+1)'(BAUD * OVS);
  localparam logic [AW:0] LIM_V  = (AW+1)'(CLK_HZ);

  logic [AW-1:0] acc;
  logic [AW:0]   sum;

  always_comb sum = {1'b0, acc} + STEP_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      tick_o <= 1'b0;
    end else if (sum >= LIM_V) begin
      acc    <= AW'(sum - LIM_V);
      tick_o <= 1'b1;
    end else begin
      acc    <= sum[AW-1:0];
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fsk_frame_rx.sv
module fsk_frame_rx
  import fsk_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 carrier_i,
  input  logic                 rx_i,
  input  logic                 tick_i,
  output logic                 valid_o,
  output logic [DATA_BITS:0]   bits_o
);
  localparam int FW = DATA_BITS + 1;
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(FW);
  localparam logic [CW-1:0] MID_C  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);
  localparam logic [IW-1:0] IDX_END = IW'(FW - 1);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          rx_m, rx_s, rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      bits_o  <= '1;
      valid_o <= 1'b0;
      rx_m    <= 1'b1;
      rx_s    <= 1'b1;
      rx_q    <= 1'b1;
    end else begin
      rx_m    <= rx_i;
      rx_s    <= rx_m;
      rx_q    <= rx_s;
      valid_o <= 1'b0;
      if (!carrier_i) begin
        st <= RX_IDLE;
      end else begin
        case (st)
          RX_IDLE: begin
            if (rx_q && !rx_s) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            if (tick_i) begin
              if (cnt == MID_C) begin
                cnt <= '0;
                idx <= '0;
                st  <= rx_s ? RX_IDLE : RX_BITS;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          RX_BITS: begin
            if (tick_i) begin
              if (cnt == LAST_C) begin
                cnt         <= '0;
                bits_o[idx] <= rx_s;
                if (idx == IDX_END) begin
                  valid_o <= 1'b1;
                  st      <= RX_IDLE;
                end else begin
                  idx <= idx + 1'b1;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fsk_serial_out.sv
module fsk_serial_out #(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               carrier_i,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [DATA_BITS:0] bits_i,
  input  logic               dclk_i,
  output logic               data_o,
  output logic               rdy_n_o,
  output logic               overrun_o,
  output logic               rise_o
);
  localparam int FW = DATA_BITS + 1;
  localparam int RW = $clog2(FW + 1);
  localparam int HW = $clog2(OVS);
  localparam logic [HW-1:0] HALF_END = HW'(OVS/2 - 1);
  localparam logic [RW-1:0] RD_FULL  = RW'(FW);
  localparam logic [RW-1:0] RD_DATA  = RW'(DATA_BITS - 1);

  logic          d1, d2, d3;
  logic [FW-1:0] sh;
  logic [RW-1:0] rd_cnt;
  logic [HW-1:0] timer;
  logic          pend;

  assign rise_o = d2 & ~d3;

  always_ff @(posedge clk) begin
    if (rst) begin
      d1        <= 1'b0;
      d2        <= 1'b0;
      d3        <= 1'b0;
      sh        <= '1;
      data_o    <= 1'b1;
      rdy_n_o   <= 1'b1;
      overrun_o <= 1'b0;
      pend      <= 1'b0;
      rd_cnt    <= '0;
      timer     <= '0;
    end else begin
      d1 <= dclk_i;
      d2 <= d1;
      d3 <= d2;
      if (load_i && carrier_i) begin
        sh        <= bits_i;
        rd_cnt    <= '0;
        rdy_n_o   <= 1'b0;
        timer     <= '0;
        overrun_o <= pend;
        pend      <= 1'b1;
      end else begin
        if (rise_o) begin
          data_o  <= sh[0];
          sh      <= {1'b1, sh[FW-1:1]};
          rdy_n_o <= 1'b1;
          if (rd_cnt != RD_FULL) rd_cnt <= rd_cnt + 1'b1;
          if (rd_cnt == RD_DATA) pend <= 1'b0;
        end else if (!rdy_n_o && tick_i) begin
          if (timer == HALF_END) rdy_n_o <= 1'b1;
          else timer <= timer + 1'b1;
        end
        if (!carrier_i) rdy_n_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsk_char_reframer.sv
module fsk_char_reframer #(
  parameter int CLK_HZ    = 3579545,
  parameter int BAUD      = 1200,
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic carrier_ok_i,
  input  logic rx_bit_i,
  input  logic dclk_i,
  output logic data_o,
  output logic rdy_n_o,
  output logic overrun_o
);
  logic               os_tick;
  logic               frm_valid;
  logic [DATA_BITS:0] frm_bits;
  logic               dclk_rise;

  fsk_os_tick #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (os_tick)
  );

  fsk_frame_rx #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .carrier_i (carrier_ok_i),
    .rx_i      (rx_bit_i),
    .tick_i    (os_tick),
    .valid_o   (frm_valid),
    .bits_o    (frm_bits)
  );

  fsk_serial_out #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_out (
    .clk       (clk),
    .rst       (rst),
    .carrier_i (carrier_ok_i),
    .tick_i    (os_tick),
    .load_i    (frm_valid),
    .bits_i    (frm_bits),
    .dclk_i    (dclk_i),
    .data_o    (data_o),
    .rdy_n_o   (rdy_n_o),
    .overrun_o (overrun_o),
    .rise_o    (dclk_rise)
  );
endmodule

// File: rtl/fsk_char_reframer_chk.sv
module fsk_char_reframer_chk #(
  parameter int CLK_HZ = 3579545,
  parameter int BAUD   = 1200,
  parameter int OVS    = 16
) (
  input logic clk,
  input logic rst,
  input logic carrier_ok_i,
  input logic rdy_n_o,
  input logic data_o,
  input logic overrun_o,
  input logic load,
  input logic dclk_rise
);
  localparam int STEP   = BAUD * OVS;
  localparam int MAXLOW = (OVS/2) * ((CLK_HZ + STEP - 1) / STEP) + 4;

  int lowcnt;
  always_ff @(posedge clk) begin
    if (rst || rdy_n_o) lowcnt <= 0;
    else lowcnt <= lowcnt + 1;
  end

  AST_READY_FALLS_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n_o) |-> $past(load)); // R2
  AST_DATA_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    !dclk_rise |=> $stable(data_o)); // R3
  AST_READ_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!rdy_n_o && dclk_rise && !load) |=> rdy_n_o); // R4
  AST_READY_LOW_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    lowcnt <= MAXLOW); // R5
  AST_NO_CARRIER_IDLE: assert property (@(posedge clk) disable iff (rst)
    !carrier_ok_i |=> rdy_n_o); // R8
  AST_OVERRUN_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(overrun_o)); // R10
endmodule

bind fsk_char_reframer fsk_char_reframer_chk #(
  .CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .carrier_ok_i (carrier_ok_i),
  .rdy_n_o      (rdy_n_o),
  .data_o       (data_o),
  .overrun_o    (overrun_o),
  .load         (frm_valid),
  .dclk_rise    (dclk_rise)
);

// File: tb/fsk_char_reframer_test.sv
module fsk_char_reframer_test;
  localparam int BITLEN = 40;   // 48000 / 1200 clocks per bit
  localparam int NVEC   = 7;
  // {stop, data}; last entry carries a zero stop bit
  localparam logic [8:0] VEC [0:NVEC-1] =
    '{9'h100, 9'h1FF, 9'h1A5, 9'h15A, 9'h101, 9'h180, 9'h0C3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carrier = 1'b1;
  logic rx = 1'b1;
  logic dclk = 1'b0;
  logic data_o, rdy_n_o, overrun_o;
  int   total = 0;
  int   bad   = 0;
  int   cycles = 0;

  always #5 clk = ~clk;

  fsk_char_reframer #(.CLK_HZ(48000), .BAUD(1200), .OVS(16), .DATA_BITS(8)) uut (
    .clk(clk), .rst(rst), .carrier_ok_i(carrier), .rx_bit_i(rx), .dclk_i(dclk),
    .data_o(data_o), .rdy_n_o(rdy_n_o), .overrun_o(overrun_o)
  );

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles == 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Sends start + 8 data bits, then holds the stop level and polls for ready.
  task automatic send_frame(input logic [7:0] b, input logic st, input int bl,
                            output bit fell, output int lag);
    fell = 1'b0;
    lag  = -1;
    rx = 1'b0;
    wait_n(bl);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      wait_n(bl);
    end
    rx = st;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (!rdy_n_o) begin
        fell = 1'b1;
        lag  = k;
        break;
      end
    end
  endtask

  task automatic read_bits(input int n, output logic [8:0] got, output logic rdy_first);
    got = '1;
    rdy_first = 1'b0;
    for (int i = 0; i < n; i++) begin
      dclk = 1'b1;
      wait_n(4);
      if (i == 0) rdy_first = rdy_n_o;
      dclk = 1'b0;
      wait_n(4);
      got[i] = data_o;
    end
  endtask

  initial begin
    bit         fell;
    int         lag;
    logic [8:0] got;
    logic       rf;
    int         hold;

    wait_n(4);
    check(rdy_n_o == 1'b1 && data_o == 1'b1 && overrun_o == 1'b0, "R1 in reset",
          {rdy_n_o, data_o, overrun_o}, 3'b110);
    rst = 1'b0;
    wait_n(50);
    check(rdy_n_o == 1'b1 && data_o == 1'b1 && overrun_o == 1'b0, "R1 after reset",
          {rdy_n_o, data_o, overrun_o}, 3'b110);

    // Table walk: R2 R3 R4 R6 R10
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][7:0], VEC[v][8], BITLEN, fell, lag);
      check(fell, "R2 ready fell", int'(fell), 1);
      check(lag >= 15 && lag <= 34, "R2 load at mid stop", lag, 25);
      check(overrun_o == 1'b0, "R10 no overrun after full read", overrun_o, 0);
      read_bits(9, got, rf);
      rx = 1'b1;
      check(rf == 1'b1, "R4 first read edge clears ready", rf, 1);
      check(got[7:0] == VEC[v][7:0], "R3 data order", got[7:0], VEC[v][7:0]);
      check(got[8] == VEC[v][8], "R6 stop bit", got[8], VEC[v][8]);
      wait_n(BITLEN);
    end

    // R3 edges past the ninth give ones
    read_bits(3, got, rf);
    check(got[2:0] == 3'b111, "R3 extra edges give ones", got[2:0], 3'b111);

    // R5 timed release without a read edge
    send_frame(8'h96, 1'b1, BITLEN, fell, lag);
    rx = 1'b1;
    hold = 0;
    while (!rdy_n_o && hold < 80) begin
      @(negedge clk);
      hold++;
    end
    check(fell && hold >= 14 && hold <= 24, "R5 half bit release", hold, 20);
    read_bits(9, got, rf);
    check(got == 9'h196, "R5 byte kept after timeout", got, 9'h196);
    wait_n(BITLEN);

    // R7 short start glitch rejected
    rx = 1'b0;
    wait_n(12);
    rx = 1'b1;
    fell = 1'b0;
    for (int k = 0; k < 12 * BITLEN; k++) begin
      @(negedge clk);
      if (!rdy_n_o) fell = 1'b1;
    end
    check(!fell, "R7 glitch ignored", int'(fell), 0);

    // R9 faster sender (39 clocks per bit, about 1231 baud vs 1200 nominal)
    send_frame(8'hC3, 1'b1, 39, fell, lag);
    read_bits(9, got, rf);
    rx = 1'b1;
    check(fell && got == 9'h1C3, "R9 fast rate byte", got, 9'h1C3);
    wait_n(BITLEN);

    // R10 overrun: partial read then new byte
    send_frame(8'h11, 1'b1, BITLEN, fell, lag);
    read_bits(3, got, rf);
    rx = 1'b1;
    wait_n(BITLEN);
    send_frame(8'h22, 1'b1, BITLEN, fell, lag);
    check(overrun_o == 1'b1, "R10 overrun set", overrun_o, 1);
    read_bits(9, got, rf);
    rx = 1'b1;
    check(got == 9'h122, "R10 newer byte replaces older", got, 9'h122);
    wait_n(BITLEN);
    send_frame(8'h33, 1'b1, BITLEN, fell, lag);
    check(overrun_o == 1'b0, "R10 overrun cleared", overrun_o, 0);
    read_bits(9, got, rf);
    rx = 1'b1;
    wait_n(BITLEN);

    // R8 carrier off: line ignored, no reload
    carrier = 1'b0;
    send_frame(8'h3C, 1'b1, BITLEN, fell, lag);
    rx = 1'b1;
    check(!fell, "R8 no ready without carrier", int'(fell), 0);
    carrier = 1'b1;
    wait_n(BITLEN);
    read_bits(9, got, rf);
    check(got == 9'h1FF, "R8 register not reloaded", got, 9'h1FF);
    check(overrun_o == 1'b0, "R8 overrun untouched", overrun_o, 0);

    // R8 carrier drop while ready low
    send_frame(8'h5C, 1'b1, BITLEN, fell, lag);
    rx = 1'b1;
    carrier = 1'b0;
    wait_n(3);
    check(rdy_n_o == 1'b1, "R8 carrier drop releases ready", rdy_n_o, 1);
    carrier = 1'b1;
    read_bits(9, got, rf);
    check(got == 9'h15C, "R8 byte readable after drop", got, 9'h15C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule